// File: doc/BRIEF.md
# Word-serial Montgomery modular multiplier

This block forms the Montgomery product of two residues over an odd modulus p. The result is a·b·2^-(W·N) mod p, where W is the word width and N the number of words in an operand. Software keeps its operands in Montgomery form, so every field multiplication becomes one call of this block. The block needs no trial division. It also needs the single-word constant m' = −p⁻¹ mod 2^W, which the caller computes once per modulus and supplies as an input.

Each of the N reduction steps takes one word of a and works out the quotient digit q from the low word of the running sum. It then adds a_i·b + q·p and drops the low word, which is now zero. The word products are spread over NCOL parallel columns. Each column is a three-register pipeline that selects words, multiplies and accumulates, then merges the columns. Area and speed are set by NCOL (1, 2 or 4) at build time. A final conditional subtraction leaves the result below p. The multipliers are written as plain logic products, and no vendor multiplier primitive is instantiated. The default build is 256-bit (W=32, N=8). The 128-bit case uses N=4.

Top module: `mont_mul_ws`

## Requirements
- R1: For odd p < 2^(W·N) and a, b < p, `result` equals a·b·2^-(W·N) mod p and is strictly less than p.
- R2: `done` is high for exactly one cycle. It rises N·(N/NCOL + 5) + 1 clock edges after the edge that accepted `start`.
- R3: `op_a`, `op_b`, `modulus` and `m_prime` are sampled only on the edge that accepts `start`. Later changes to them do not alter the result.
- R4: A `start` pulse that arrives while a computation is in progress is ignored. It does not restart the operation and produces no second `done`.
- R5: After reset, `done` is 0 and `result` is 0. `result` changes only on the edge that raises `done` and holds its value between `done` pulses.
- R6: The running sum stays below 2p before every reduction step. The worst-case operands a = b = p − 1, with p close to 2^(W·N), therefore still yield the exact product.
- R7: A zero operand yields a zero result. An operand equal to 2^(W·N) mod p returns the other operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| op_a | input | W·N | Multiplicand a, below modulus |
| op_b | input | W·N | Multiplier b, below modulus |
| modulus | input | W·N | Odd modulus p |
| m_prime | input | W | −p⁻¹ mod 2^W |
| done | output | 1 | One-cycle pulse when `result` is valid |
| result | output | W·N | Reduced Montgomery product |

## Verification
The hardest situation to reach is a running sum near its 2p bound, where the final subtraction decides the answer and an accumulator one bit too narrow would wrap. A small build (W=4, N=2) is swept over every operand pair for two moduli and over a strided grid for a third. This walks through every subtraction outcome. A 256-bit build with four columns then receives random operands, a = b = p − 1 against a modulus just below 2^256, and a second start pulse in the middle of a run. Expected values come from a model that reduces a·b mod p and then halves modulo p W·N times.

// File: rtl/mont_mul_ws.sv
module mont_mul_ws #(
  parameter int W      = 32,
  parameter int NWORDS = 8,
  parameter int NCOL   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [W*NWORDS-1:0] op_a,
  input  logic [W*NWORDS-1:0] op_b,
  input  logic [W*NWORDS-1:0] modulus,
  input  logic [W-1:0]        m_prime,
  output logic                done,
  output logic [W*NWORDS-1:0] result
);
  localparam int NW  = W * NWORDS;
  localparam int G   = NWORDS / NCOL;
  localparam int TW  = NW + W + 2;
  localparam int PW  = 2 * W + 1;
  localparam int PSW = (NCOL + 1) * W + 2;
  localparam int GSH = NCOL * W;
  localparam int CW  = $clog2(G + 3) + 1;
  localparam int IW  = $clog2(NWORDS) + 1;

  typedef enum logic [2:0] {IDLE, QSTEP, RUN, SHIFT, FIN} st_t;
  st_t st;

  logic [NW-1:0] a_r, b_r, p_r;
  logic [W-1:0]  mp_r, q_r;
  logic [TW-1:0] t_r;
  logic [CW-1:0] cyc, gsel;
  logic [IW-1:0] it;

  logic           ld1, s1_v, s2_v, s3_v;
  logic [CW-1:0]  s1_g, s2_g, s3_g;
  logic [W-1:0]   s1_a, s1_q;
  logic [W-1:0]   s1_b [NCOL];
  logic [W-1:0]   s1_p [NCOL];
  logic [PW-1:0]  s2_pr [NCOL];
  logic [PSW-1:0] grp, s3_sum;

  logic idle_s, qphase;
  assign idle_s = (st == IDLE);
  assign qphase = (st == QSTEP);
  assign ld1    = (st == RUN) && (cyc < CW'(G));
  assign gsel   = ld1 ? cyc : '0;

  for (genvar k = 0; k < NCOL; k++) begin : g_col
    always_ff @(posedge clk) begin
      if (ld1) begin
        s1_b[k] <= b_r[W*(NCOL*int'(gsel) + k) +: W];
        s1_p[k] <= p_r[W*(NCOL*int'(gsel) + k) +: W];
      end
      s2_pr[k] <= PW'(s1_a) * PW'(s1_b[k]) + PW'(s1_q) * PW'(s1_p[k]);
    end
  end

  always_comb begin
    grp = '0;
    for (int k = 0; k < NCOL; k++) grp = grp + (PSW'(s2_pr[k]) << (k * W));
  end

  always_ff @(posedge clk) begin
    if (ld1) begin
      s1_a <= a_r[W-1:0];
      s1_q <= q_r;
      s1_g <= cyc;
    end
    s2_g   <= s1_g;
    s3_g   <= s2_g;
    s3_sum <= grp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      done   <= 1'b0;
      result <= '0;
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      s3_v   <= 1'b0;
      cyc    <= '0;
      it     <= '0;
    end else begin
      done <= 1'b0;
      s1_v <= ld1;
      s2_v <= s1_v;
      s3_v <= s2_v;
      if (s3_v) t_r <= t_r + (TW'(s3_sum) << (int'(s3_g) * GSH));
      case (st)
        IDLE: if (start) begin
          a_r  <= op_a;
          b_r  <= op_b;
          p_r  <= modulus;
          mp_r <= m_prime;
          t_r  <= '0;
          it   <= '0;
          st   <= QSTEP;
        end
        QSTEP: begin
          q_r <= (t_r[W-1:0] + a_r[W-1:0] * b_r[W-1:0]) * mp_r;
          cyc <= '0;
          st  <= RUN;
        end
        RUN: begin
          cyc <= cyc + 1'b1;
          if (cyc == CW'(G + 2)) st <= SHIFT;
        end
        SHIFT: begin
          t_r <= t_r >> W;
          a_r <= a_r >> W;
          it  <= it + 1'b1;
          st  <= (it == IW'(NWORDS - 1)) ? FIN : QSTEP;
        end
        FIN: begin
          if (t_r >= TW'(p_r)) result <= NW'(t_r - TW'(p_r));
          else                 result <= NW'(t_r);
          done <= 1'b1;
          st   <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module mont_mul_ws_chk #(
  parameter int W      = 32,
  parameter int NWORDS = 8,
  parameter int NCOL   = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      done,
  input logic [W*NWORDS-1:0]       result,
  input logic [W*NWORDS-1:0]       p_r,
  input logic [W*NWORDS+W+1:0]     t_r,
  input logic                      idle_s,
  input logic                      qphase
);
  localparam int NW  = W * NWORDS;
  localparam int TW  = NW + W + 2;
  localparam int LAT = NWORDS * (NWORDS / NCOL + 5) + 1;

  int cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= 0;
    else if (start && idle_s) cnt <= 1;
    else if (done)           cnt <= 0;
    else if (cnt != 0)       cnt <= cnt + 1;
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> cnt == LAT + 1);
  // R1
  reduced_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> result < p_r);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done);
  // R6
  bound_chk: assert property (@(posedge clk) disable iff (!rst_n) qphase |-> t_r < (TW'(p_r) << 1));
endmodule

bind mont_mul_ws mont_mul_ws_chk #(.W(W), .NWORDS(NWORDS), .NCOL(NCOL)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .result(result),
  .p_r(p_r), .t_r(t_r), .idle_s(idle_s), .qphase(qphase)
);

// File: tb/test_mont_mul_ws.sv
module test_mont_mul_ws;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_S = 2 * (2 / 1 + 5) + 1;
  localparam int LAT_L = 8 * (8 / 4 + 5) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]   sa, sb, sp, sres;
  logic [3:0]   spi;
  logic         sstart, sdone;
  logic [255:0] la, lb, lp, lres;
  logic [31:0]  lpi;
  logic         lstart, ldone;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  mont_mul_ws #(.W(4), .NWORDS(2), .NCOL(1)) i_mont_mul_ws (
    .clk(clk), .rst_n(rst_n), .start(sstart), .op_a(sa), .op_b(sb),
    .modulus(sp), .m_prime(spi), .done(sdone), .result(sres));

  mont_mul_ws #(.W(32), .NWORDS(8), .NCOL(4)) i_mont_mul_ws_big (
    .clk(clk), .rst_n(rst_n), .start(lstart), .op_a(la), .op_b(lb),
    .modulus(lp), .m_prime(lpi), .done(ldone), .result(lres));

  function automatic logic [511:0] ref_mont(input logic [511:0] a, b, p, input int nbits);
    logic [1023:0] x, pp;
    pp = {512'd0, p};
    x  = ({512'd0, a} * {512'd0, b}) % pp;
    for (int i = 0; i < nbits; i++) x = x[0] ? (x + pp) >> 1 : x >> 1;
    return x[511:0];
  endfunction

  function automatic logic [31:0] mprime(input logic [31:0] p0, input int w);
    logic [31:0] inv = 32'd1;
    logic [31:0] mask;
    for (int i = 0; i < 6; i++) inv = inv * (32'd2 - p0 * inv);
    mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (32'd0 - inv) & mask;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [511:0] act, input logic [511:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_small(input logic [7:0] a, input logic [7:0] b, input logic [7:0] p);
    logic [7:0] exp;
    int lat;
    exp = ref_mont({504'd0, a}, {504'd0, b}, {504'd0, p}, 8);
    @(negedge clk);
    sa = a; sb = b; sp = p; spi = mprime({24'd0, p}, 4)[3:0]; sstart = 1'b1;
    @(negedge clk);
    sstart = 1'b0; sa = ~a; sb = ~b; sp = ~p; spi = ~spi;  // R3 scramble after start
    lat = 0;
    while (!sdone && lat < 100) begin @(negedge clk); lat++; end
    chk(lat == LAT_S, "R2 latency", lat, LAT_S);
    chk(sres == exp, "R1 product", sres, exp);
  endtask

  task automatic run_big(input logic [255:0] a, input logic [255:0] b, input logic [255:0] p,
                         input string rq, input bit mid);
    logic [255:0] exp;
    int lat;
    exp = ref_mont({256'd0, a}, {256'd0, b}, {256'd0, p}, 256);
    @(negedge clk);
    la = a; lb = b; lp = p; lpi = mprime(p[31:0], 32); lstart = 1'b1;
    @(negedge clk);
    lstart = 1'b0; la = ~a; lb = b ^ 256'h5A; lp = ~p;  // R3 scramble after start
    lat = 0;
    while (!ldone && lat < 200) begin
      @(negedge clk); lat++;
      lstart = (mid && lat == 10);  // R4 second request mid-run
    end
    lstart = 1'b0;
    chk(lat == LAT_L, "R2 latency", lat, LAT_L);
    chk(lres == exp, rq, lres, exp);
    if (mid) begin
      int extra = 0;
      for (int i = 0; i < LAT_L + 5; i++) begin
        @(negedge clk);
        if (ldone) extra++;
      end
      chk(extra == 0, "R4 no second done", extra, 0);
      chk(lres == exp, "R5 result held", lres, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (CLK_PERIOD * 19000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] p, a, b, rm;
    logic [511:0] r512;
    sstart = 0; lstart = 0; sa = 0; sb = 0; sp = 1; spi = 0;
    la = 0; lb = 0; lp = 1; lpi = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R5 reset state
    chk(!sdone && !ldone, "R5 done after reset", {ldone, sdone}, 0);
    chk(sres == 0 && lres == 0, "R5 result after reset", {lres, sres}, 0);

    // R1 exhaustive over small moduli
    for (int a = 0; a < 13; a++) for (int b = 0; b < 13; b++) run_small(8'(a), 8'(b), 8'd13);
    for (int a = 0; a < 61; a++) for (int b = 0; b < 61; b++) run_small(8'(a), 8'(b), 8'd61);
    // R6 strided grid incl. p-1 at the top of an 8-bit modulus
    for (int a = 0; a < 251; a += 17) for (int b = 0; b < 251; b += 17) run_small(8'(a), 8'(b), 8'd251);
    run_small(8'd250, 8'd250, 8'd251);

    // R7 zero and identity on the wide build
    p = rnd256(); p[255] = 1'b1; p[0] = 1'b1;
    r512 = {256'd1, 256'd0} % {256'd0, p};
    rm = r512[255:0];
    b = rnd256() % p;
    run_big(256'd0, b, p, "R7 zero operand", 1'b0);
    run_big(rm, b, p, "R7 identity", 1'b0);
    chk(lres == b, "R7 identity returns b", lres, b);

    // R6 worst-case operands, modulus just below 2^256
    p = 256'd0 - 256'd189;
    run_big(p - 1, p - 1, p, "R6 max operands", 1'b0);

    // R4 start during a run, R5 hold
    p = rnd256(); p[255] = 1'b1; p[0] = 1'b1;
    run_big(rnd256() % p, rnd256() % p, p, "R4 product with mid start", 1'b1);

    // R1 random wide operands
    for (int i = 0; i < 120; i++) begin
      p = rnd256(); p[255] = (i % 3 != 0); p[0] = 1'b1;
      if (p < 3) p = 256'd3;
      a = rnd256() % p; b = rnd256() % p;
      run_big(a, b, p, "R1 random product", 1'b0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule